// File: doc/BRIEF.md
# Opcode Length and Timing Decoder

This block sits beside the fetch unit of an 8-bit processor whose instructions vary in length. It receives one opcode byte together with two qualifiers. The first qualifier says that the byte came from the second page, reached through the 0xCB prefix. The second says whether a conditional branch will be taken. One clock later the block reports four things about the byte:
- its quadrant, taken from the top two bits;
- the total instruction length in bytes;
- the execution time in machine cycles, where one machine cycle is four clock ticks;
- flags marking prefixed operations, the halt encoding and illegal opcode holes.

A sticky lock output records that an illegal opcode has been seen. The fetch sequencer uses it to freeze the core until the next reset. The block does not evaluate conditions: the caller works out taken or not taken and supplies it.

Top module: `opdec_timing`

## Requirements
- R1: While `rst` is high, and after it falls until the first accepted byte, every output is 0.
- R2: A byte presented with `op_valid` high produces its results, with `out_valid` high, on the next clock edge. A cycle without `op_valid` drops `out_valid` and leaves the other decode outputs unchanged.
- R3: `out_quad` equals bits 7:6 of the accepted byte: 0 is miscellaneous, 1 is register loads, 2 is accumulator arithmetic and 3 is immediate, control and stack.
- R4: `out_len` is 1 plus one byte for an 8-bit immediate or two bytes for a 16-bit immediate (for example 0x06 gives 2 and 0x01 gives 3). Stop (0x10) gives 2. The prefix byte 0xCB and every second-page operation also give 2.
- R5: On the first page, 0x76 reports `out_halt` = 1 with length 1 and 1 cycle. No other byte, and no second-page byte, raises `out_halt`.
- R6: On the first page, 0xD3, 0xDB, 0xDD, 0xE3, 0xE4, 0xEB, 0xEC, 0xED, 0xF4, 0xFC and 0xFD raise `out_illegal` with length 1 and 1 cycle. No other byte raises it.
- R7: `lock` rises together with the first reported illegal opcode. It then stays high whatever bytes follow, until `rst`.
- R8: A 3-bit register field equal to 6 selects the memory byte at HL. This makes quadrant 1 and 2 operations 2 cycles instead of 1, inc/dec r8 (0x34, 0x35) 3 cycles instead of 1, and 0x36 3 cycles instead of 2.
- R9: Conditional operations cost taken/not-taken machine cycles as follows: absolute jump (110cc010) 4/3, relative jump (001cc000) 3/2, call (110cc100) 6/3, return (110cc000) 5/2. `br_taken` has no effect on any other opcode.
- R10: With `op_page2` high, `out_pfx` = 1 and `out_len` = 2. The cycle count is 2 for a register operand. For the HL memory operand it is 3 for bit tests (bits 7:6 = 01) and 4 for all other operations.
- R11: The remaining first-page timings in cycles are: 0x08 is 5; 0x18 and 0x0?1-class immediate loads are 3; 16-bit inc/dec, add HL and indirect accumulator loads are 2; pop is 3; push, rst, 0xC3, 0xC9, 0xD9, 0xEA and 0xFA are 4; call 0xCD is 6; 0xE8 is 4; 0xE0, 0xF0 and 0xF8 are 3; 0xE2, 0xF2, 0xF9 and the immediate ALU forms are 2; 0xE9, 0xF3, 0xFB and the 00???111 group are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Opcode byte is present this cycle |
| op_byte | input | 8 | Opcode byte |
| op_page2 | input | 1 | Byte belongs to the page after the 0xCB prefix |
| br_taken | input | 1 | Conditional branch will be taken |
| out_valid | output | 1 | Decode results updated this cycle |
| out_quad | output | 2 | Opcode quadrant |
| out_len | output | 2 | Instruction length in bytes (1 to 3) |
| out_cyc | output | 3 | Execution time in machine cycles |
| out_pfx | output | 1 | Prefix byte or second-page operation |
| out_halt | output | 1 | Halt encoding detected |
| out_illegal | output | 1 | Opcode hole detected |
| lock | output | 1 | Sticky illegal-opcode lock |

## Verification
Two things can land in the same cycle: an illegal opcode's own decode report, and the rise of the sticky lock. A second overlap is the lock already being set while later legal bytes are decoded.

The bench sends every hole directly and mixes holes into random streams. For each accepted byte it checks that the illegal flag and the lock appear on the same edge. It then checks that later legal bytes still decode correctly while the lock stays high, and that only a reset clears the lock.

// File: rtl/opdec_pkg.sv
package opdec_pkg;
  localparam int BYTE_W = 8;
  localparam int LEN_W  = 2;
  localparam int CYC_W  = 3;
  localparam int QUAD_W = 2;
  localparam int NUM_HOLES = 11;

  typedef struct packed {
    logic [LEN_W-1:0] len;
    logic [CYC_W-1:0] cyc;
    logic             pfx;
    logic             halt;
  } dec_t;

  localparam logic [BYTE_W-1:0] HOLE_LIST [NUM_HOLES] = '{
    8'hD3, 8'hDB, 8'hDD, 8'hE3, 8'hE4, 8'hEB,
    8'hEC, 8'hED, 8'hF4, 8'hFC, 8'hFD
  };

  localparam logic [2:0] MEM_SEL = 3'd6;
endpackage

// File: rtl/opdec_hole_detect.sv
module opdec_hole_detect
  import opdec_pkg::*;
(
  input  logic [BYTE_W-1:0] byte_in,
  output logic              is_hole
);
  logic [NUM_HOLES-1:0] hit;

  for (genvar g = 0; g < NUM_HOLES; g++) begin : g_cmp
    assign hit[g] = (byte_in == HOLE_LIST[g]);
  end

  assign is_hole = |hit;
endmodule

// File: rtl/opdec_page0.sv
module opdec_page0
  import opdec_pkg::*;
(
  input  logic [BYTE_W-1:0] op,
  input  logic              taken,
  output dec_t              res
);
  logic [2:0] lo;
  logic [2:0] mid;
  logic       mid_mem;
  logic       lo_mem;

  assign lo      = op[2:0];
  assign mid     = op[5:3];
  assign mid_mem = (mid == MEM_SEL);
  assign lo_mem  = (lo == MEM_SEL);

  always_comb begin
    res = '{len: 2'd1, cyc: 3'd1, pfx: 1'b0, halt: 1'b0};
    unique case (op[7:6])
      2'b00: begin
        unique case (lo)
          3'b000: begin
            unique case (mid)
              3'd0: ;
              3'd1: begin res.len = 2'd3; res.cyc = 3'd5; end
              3'd2: res.len = 2'd2;
              3'd3: begin res.len = 2'd2; res.cyc = 3'd3; end
              default: begin
                res.len = 2'd2;
                res.cyc = taken ? 3'd3 : 3'd2;
              end
            endcase
          end
          3'b001: begin
            if (op[3]) res.cyc = 3'd2;
            else begin res.len = 2'd3; res.cyc = 3'd3; end
          end
          3'b010, 3'b011: res.cyc = 3'd2;
          3'b100, 3'b101: res.cyc = mid_mem ? 3'd3 : 3'd1;
          3'b110: begin
            res.len = 2'd2;
            res.cyc = mid_mem ? 3'd3 : 3'd2;
          end
          default: ;
        endcase
      end
      2'b01: begin
        if (mid_mem && lo_mem) res.halt = 1'b1;
        else if (mid_mem || lo_mem) res.cyc = 3'd2;
      end
      2'b10: res.cyc = lo_mem ? 3'd2 : 3'd1;
      default: begin
        unique case (lo)
          3'b000: begin
            if (!op[5]) res.cyc = taken ? 3'd5 : 3'd2;
            else begin
              res.len = 2'd2;
              res.cyc = (op[4:3] == 2'b01) ? 3'd4 : 3'd3;
            end
          end
          3'b001: begin
            if (!op[3]) res.cyc = 3'd3;
            else begin
              unique case (op[5:4])
                2'b00, 2'b01: res.cyc = 3'd4;
                2'b10: res.cyc = 3'd1;
                default: res.cyc = 3'd2;
              endcase
            end
          end
          3'b010: begin
            if (!op[5]) begin
              res.len = 2'd3;
              res.cyc = taken ? 3'd4 : 3'd3;
            end else if (op[3]) begin
              res.len = 2'd3; res.cyc = 3'd4;
            end else res.cyc = 3'd2;
          end
          3'b011: begin
            if (mid == 3'd0) begin res.len = 2'd3; res.cyc = 3'd4; end
            else if (mid == 3'd1) begin
              res.len = 2'd2; res.cyc = 3'd2; res.pfx = 1'b1;
            end
          end
          3'b100: begin
            if (!op[5]) begin
              res.len = 2'd3;
              res.cyc = taken ? 3'd6 : 3'd3;
            end
          end
          3'b101: begin
            if (!op[3]) res.cyc = 3'd4;
            else if (op[5:4] == 2'b00) begin res.len = 2'd3; res.cyc = 3'd6; end
          end
          3'b110: begin res.len = 2'd2; res.cyc = 3'd2; end
          default: res.cyc = 3'd4;
        endcase
      end
    endcase
  end
endmodule

// File: rtl/opdec_page1.sv
module opdec_page1
  import opdec_pkg::*;
(
  input  logic [BYTE_W-1:0] op,
  output dec_t              res
);
  logic mem_op;
  logic bit_test;

  assign mem_op   = (op[2:0] == MEM_SEL);
  assign bit_test = (op[7:6] == 2'b01);

  always_comb begin
    res.len  = 2'd2;
    res.pfx  = 1'b1;
    res.halt = 1'b0;
    if (!mem_op)       res.cyc = 3'd2;
    else if (bit_test) res.cyc = 3'd3;
    else               res.cyc = 3'd4;
  end
endmodule

// File: rtl/opdec_timing.sv
module opdec_timing
  import opdec_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic [BYTE_W-1:0] op_byte,
  input  logic              op_page2,
  input  logic              br_taken,
  output logic              out_valid,
  output logic [QUAD_W-1:0] out_quad,
  output logic [LEN_W-1:0]  out_len,
  output logic [CYC_W-1:0]  out_cyc,
  output logic              out_pfx,
  output logic              out_halt,
  output logic              out_illegal,
  output logic              lock
);
  dec_t d0, d1, dsel;
  logic hole_raw;
  logic hole;

  opdec_page0 i_page0 (.op(op_byte), .taken(br_taken), .res(d0));
  opdec_page1 i_page1 (.op(op_byte), .res(d1));
  opdec_hole_detect i_holes (.byte_in(op_byte), .is_hole(hole_raw));

  assign hole = hole_raw && !op_page2;
  assign dsel = op_page2 ? d1 : d0;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_quad    <= '0;
      out_len     <= '0;
      out_cyc     <= '0;
      out_pfx     <= 1'b0;
      out_halt    <= 1'b0;
      out_illegal <= 1'b0;
      lock        <= 1'b0;
    end else begin
      out_valid <= op_valid;
      if (op_valid) begin
        out_quad    <= op_byte[7:6];
        out_len     <= dsel.len;
        out_cyc     <= dsel.cyc;
        out_pfx     <= dsel.pfx;
        out_halt    <= dsel.halt;
        out_illegal <= hole;
        if (hole) lock <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/opdec_timing_chk.sv
module opdec_timing_chk
  import opdec_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              op_valid,
  input logic [BYTE_W-1:0] op_byte,
  input logic              out_valid,
  input logic [QUAD_W-1:0] out_quad,
  input logic [LEN_W-1:0]  out_len,
  input logic [CYC_W-1:0]  out_cyc,
  input logic              out_pfx,
  input logic              out_halt,
  input logic              out_illegal,
  input logic              lock
);
  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
    op_valid |=> out_valid);
  assert_valid_drops_R2: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> !out_valid);
  assert_quad_track_R3: assert property (@(posedge clk) disable iff (rst)
    op_valid |=> (out_quad == $past(op_byte[7:6])));
  assert_len_nonzero_R4: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_len != 2'd0 && out_cyc != 3'd0));
  assert_halt_shape_R5: assert property (@(posedge clk) disable iff (rst)
    out_halt |-> (out_quad == 2'd1 && out_len == 2'd1 && !out_pfx && !out_illegal));
  assert_lock_cause_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(lock) |-> (out_valid && out_illegal));
  assert_lock_hold_R7: assert property (@(posedge clk) disable iff (rst)
    lock |=> lock);
  assert_illegal_locks_R7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_illegal) |-> lock);
  assert_pfx_shape_R10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_pfx) |-> (out_len == 2'd2 && !out_illegal && !out_halt));
endmodule

bind opdec_timing opdec_timing_chk i_chk (
  .clk(clk), .rst(rst), .op_valid(op_valid), .op_byte(op_byte),
  .out_valid(out_valid), .out_quad(out_quad), .out_len(out_len),
  .out_cyc(out_cyc), .out_pfx(out_pfx), .out_halt(out_halt),
  .out_illegal(out_illegal), .lock(lock)
);

// File: tb/test_opdec_timing.sv
module test_opdec_timing;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       op_valid = 1'b0;
  logic [7:0] op_byte = 8'h00;
  logic       op_page2 = 1'b0;
  logic       br_taken = 1'b0;
  logic       out_valid, out_pfx, out_halt, out_illegal, lock;
  logic [1:0] out_quad, out_len;
  logic [2:0] out_cyc;

  int n_checks = 0;
  int n_fail = 0;
  bit exp_lock = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  opdec_timing i_opdec_timing (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_byte(op_byte),
    .op_page2(op_page2), .br_taken(br_taken), .out_valid(out_valid),
    .out_quad(out_quad), .out_len(out_len), .out_cyc(out_cyc),
    .out_pfx(out_pfx), .out_halt(out_halt), .out_illegal(out_illegal),
    .lock(lock)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Reference table: returns {len[1:0], cyc[2:0], pfx, halt, ill}
  function automatic logic [7:0] model(input logic [7:0] b, input bit pg2, input bit tk);
    logic [1:0] l; logic [2:0] c; bit p, h, i;
    l = 2'd1; c = 3'd1; p = 0; h = 0; i = 0;
    if (pg2) begin
      l = 2'd2; p = 1;
      if (b[2:0] != 3'd6) c = 3'd2;
      else if (b[7:6] == 2'b01) c = 3'd3;
      else c = 3'd4;
    end else begin
      casez (b)
        8'hD3, 8'hDB, 8'hDD, 8'hE3, 8'hE4, 8'hEB,
        8'hEC, 8'hED, 8'hF4, 8'hFC, 8'hFD: i = 1;
        8'h00: ;
        8'h08: begin l = 3; c = 5; end
        8'h10: l = 2;
        8'h18: begin l = 2; c = 3; end
        8'b001??000: begin l = 2; c = tk ? 3 : 2; end
        8'b00??0001: begin l = 3; c = 3; end
        8'b00??1001: c = 2;
        8'b00???010, 8'b00???011: c = 2;
        8'h34, 8'h35: c = 3;
        8'b00???10?: c = 1;
        8'h36: begin l = 2; c = 3; end
        8'b00???110: begin l = 2; c = 2; end
        8'b00???111: c = 1;
        8'h76: h = 1;
        8'b01110???, 8'b01???110: c = 2;
        8'b01??????: c = 1;
        8'b10???110: c = 2;
        8'b10??????: c = 1;
        8'b110??000: c = tk ? 5 : 2;
        8'hE0, 8'hF0, 8'hF8: begin l = 2; c = 3; end
        8'hE8: begin l = 2; c = 4; end
        8'b11??0001: c = 3;
        8'hC9, 8'hD9: c = 4;
        8'hE9: c = 1;
        8'hF9: c = 2;
        8'b110??010: begin l = 3; c = tk ? 4 : 3; end
        8'hE2, 8'hF2: c = 2;
        8'hEA, 8'hFA, 8'hC3: begin l = 3; c = 4; end
        8'hCB: begin l = 2; c = 2; p = 1; end
        8'hF3, 8'hFB: c = 1;
        8'b110??100: begin l = 3; c = tk ? 6 : 3; end
        8'b11??0101: c = 4;
        8'hCD: begin l = 3; c = 6; end
        8'b11???110: begin l = 2; c = 2; end
        8'b11???111: c = 4;
        default: ;
      endcase
    end
    return {l, c, p, h, i};
  endfunction

  task automatic issue(input logic [7:0] b, input bit pg2, input bit tk, input string ctag);
    logic [7:0] e;
    e = model(b, pg2, tk);
    @(negedge clk);
    op_byte = b; op_page2 = pg2; br_taken = tk; op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
    if (e[0]) exp_lock = 1'b1;
    chk(out_valid == 1'b1, "R2 out_valid", out_valid, 1);
    chk(out_quad == b[7:6], "R3 quad", out_quad, b[7:6]);
    chk(out_len == e[7:6], "R4 len", out_len, e[7:6]);
    chk(out_cyc == e[5:3], ctag, out_cyc, e[5:3]);
    chk(out_pfx == e[2], "R10 pfx", out_pfx, e[2]);
    chk(out_halt == e[1], "R5 halt", out_halt, e[1]);
    chk(out_illegal == e[0], "R6 illegal", out_illegal, e[0]);
    chk(lock == exp_lock, "R7 lock", lock, exp_lock);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; op_valid = 1'b1; op_byte = 8'hD3; op_page2 = 1'b0;
    repeat (2) @(negedge clk);
    chk({out_valid, out_quad, out_len, out_cyc, out_pfx, out_halt, out_illegal, lock} == '0,
        "R1 reset outputs", {out_valid, lock}, 0);
    op_valid = 1'b0; rst = 1'b0; exp_lock = 1'b0;
    @(negedge clk);
    chk({out_valid, out_quad, out_len, out_cyc, out_pfx, out_halt, out_illegal, lock} == '0,
        "R1 after release", {out_valid, lock}, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [1:0] hold_len;
    logic [2:0] hold_cyc;
    void'($urandom(32'h5eed1234));
    do_reset();

    // R5 halt, R8 memory operand
    issue(8'h76, 0, 0, "R5 halt cyc");
    issue(8'h76, 1, 0, "R10 cyc page2 76");
    issue(8'h46, 0, 0, "R8 ld r,[hl]");
    issue(8'h70, 0, 0, "R8 ld [hl],r");
    issue(8'h41, 0, 0, "R8 ld r,r");
    issue(8'h86, 0, 0, "R8 alu [hl]");
    issue(8'h80, 0, 0, "R8 alu r");
    issue(8'h34, 0, 0, "R8 inc [hl]");
    issue(8'h35, 0, 0, "R8 dec [hl]");
    issue(8'h36, 0, 0, "R8 ld [hl],n");
    // R9 conditionals taken / not taken, unconditional ignores br_taken
    for (int t = 0; t < 2; t++) begin
      issue(8'hC2, t[0], 0, "R9 jp cc");
      issue(8'hC2, 0, t[0], "R9 jp cc");
      issue(8'h38, 0, t[0], "R9 jr cc");
      issue(8'hDC, 0, t[0], "R9 call cc");
      issue(8'hC8, 0, t[0], "R9 ret cc");
      issue(8'hCD, 0, t[0], "R9 call uncond");
      issue(8'h18, 0, t[0], "R9 jr uncond");
    end
    // R4 lengths and R11 fixed timings
    issue(8'h10, 0, 0, "R4 stop");
    issue(8'h01, 0, 0, "R11 ld r16,nn");
    issue(8'h08, 0, 0, "R11 ld [nn],sp");
    issue(8'hE8, 0, 0, "R11 add sp");
    issue(8'hF5, 0, 0, "R11 push");
    issue(8'hFF, 0, 0, "R11 rst");
    issue(8'hE9, 0, 0, "R11 jp hl");
    // R10 prefix page
    issue(8'hCB, 0, 0, "R10 prefix byte");
    issue(8'h46, 1, 0, "R10 bit [hl]");
    issue(8'h06, 1, 0, "R10 rot [hl]");
    issue(8'hC6, 1, 0, "R10 set [hl]");
    issue(8'h37, 1, 0, "R10 swap r");
    issue(8'hD3, 1, 0, "R10 hole code on page2");
    chk(lock == 1'b0, "R6 page2 no lock", lock, 0);

    // R2 hold without op_valid
    hold_len = out_len; hold_cyc = out_cyc;
    @(negedge clk);
    chk(out_valid == 1'b0, "R2 valid drop", out_valid, 0);
    chk(out_len == hold_len && out_cyc == hold_cyc, "R2 hold", out_cyc, hold_cyc);

    // R6/R7 every hole, lock and illegal in the same cycle
    foreach (opdec_pkg::HOLE_LIST[k]) begin
      do_reset();
      issue(opdec_pkg::HOLE_LIST[k], 0, 0, "R6 hole cyc");
      issue(8'h00, 0, 0, "R7 legal after lock");
      issue(8'h3E, 0, 1, "R7 legal after lock");
    end
    do_reset();
    chk(lock == 1'b0, "R7 reset clears", lock, 0);

    // Random mix
    for (int n = 0; n < 3000; n++) begin
      logic [7:0] rb;
      if (n % 500 == 499) do_reset();
      rb = 8'($urandom);
      issue(rb, ($urandom % 4) == 0, 1'($urandom), "R11 random cyc");
    end

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule